// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading translation entries from memory in a two-level hierarchy. A request carries the virtual address, the access kind (read or write) and the privilege of the requester (user or supervisor). The walker reads one directory entry, found through a base frame number that the core supplies. Unless that entry maps a 4 MB page directly, the walker then reads one table entry. It ends each request with either a completion pulse carrying the physical address or a fault pulse carrying a cause code and the faulting virtual address.

On a successful walk the walker records use in the entries. It sets the accessed flag in each entry it consulted, and it sets the dirty flag in the final entry when the access is a write. An entry is written back to memory only when one of those flags actually changes, and a faulting walk writes nothing. All memory traffic goes over one port that carries a single transaction at a time. The block holds a request until the memory acknowledges it. The walker keeps no copies of entries between requests.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from address {dir_base_frame, va[31:22], 2'b00}, i.e. base frame times 4096 plus directory index times 4.
- R2: For a 4 KB mapping, the table entry is read from address {pde[31:12], va[21:12], 2'b00}.
- R3: An entry with bit 0 (present) clear, at either level, ends the walk with fault_cause 1 (not present) and fault_vaddr equal to the request address. A faulting walk issues no memory write.
- R4: A present directory entry with bit 7 set maps a 4 MB page. The walk then reads no table entry, and pa_out is {pde[31:22], va[21:0]}.
- R5: For a 4 KB mapping, pa_out is {pte[31:12], va[11:0]}.
- R6: A user access (req_user=1) faults with cause 3 (privilege) unless bit 2 is set in every entry that applies to the mapping: the directory entry, plus the table entry for a 4 KB page. This cause takes precedence over cause 2.
- R7: A write access (req_write=1) faults with cause 2 (write protection) unless bit 1 is set in every entry that applies to the mapping. This holds in supervisor mode too.
- R8: On success, bit 5 (accessed) is set in every entry that was read. On a write, bit 6 (dirty) is also set in the final entry: the table entry, or the directory entry for a 4 MB page. No other bit changes.
- R9: An entry is written back only if its value changed. When both entries change, the directory entry is written first.
- R10: mem_req, mem_we, mem_addr and mem_wdata stay stable from the cycle a transaction is raised until the cycle mem_ack is seen, and only one transaction is outstanding.
- R11: Each accepted request yields exactly one single-cycle pulse on done or fault, never both. busy falls only in the cycle after that pulse. Fault cause 0 means no fault.
- R12: After reset, busy, done, fault and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_base_frame | input | 20 | Frame number of the directory, sampled when a request is accepted |
| req_valid | input | 1 | Translation request, accepted when busy is low |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_cause | output | 2 | 0 none, 1 not present, 2 write protection, 3 privilege |
| fault_vaddr | output | 32 | Virtual address of the current or last request |
| pa_out | output | 32 | Translated physical address, valid with done |
| mem_req | output | 1 | Memory transaction request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value for a write |
| mem_ack | input | 1 | Transaction complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Entry value returned by a read |

## Verification
The assertions take for granted that the memory raises mem_ack for one cycle only, and only while mem_req is high. They also assume mem_rdata is meaningful only in that acknowledge cycle. Every assertion on the memory port depends on this. The bench's memory model follows these rules exactly: it raises the acknowledge after 0 to 2 wait cycles, drops it on the following cycle, and returns zero for addresses that were never written. The bench offers a new request only after the previous response has been seen and busy has returned low. Every combination of the present, write, user and size flags, the preset accessed and dirty flags, the access kind and the privilege is swept once.

// File: rtl/pt_walker_pkg.sv
// Shared definitions for the page table walker.
// Assumes 32-bit entries whose flag bits are at the fixed positions listed here.
package pt_walker_pkg;

    // Result of an entry check; the encoding is visible on the fault_cause port.
    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NOT_PRESENT = 2'd1,
        FLT_WRITE_PROT  = 2'd2,
        FLT_PRIVILEGE   = 2'd3
    } fault_e;

    // Phases of one walk.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WB_DIR,
        ST_WB_TBL,
        ST_RESP
    } walk_state_e;

    // Flag positions inside an entry.
    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITABLE = 1;
    localparam int unsigned BIT_USER     = 2;
    localparam int unsigned BIT_ACCESSED = 5;
    localparam int unsigned BIT_DIRTY    = 6;
    localparam int unsigned BIT_LARGE    = 7;

endpackage

// File: rtl/pt_addr_form.sv
// Address former: builds both entry addresses and both physical address forms
// from the latched request and the entries read so far.
// Assumes OFF_W - IDX_W is the log2 of the entry size in bytes.
module pt_addr_form #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFF_W  = 12
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [ADDR_W-1:0]       vaddr,
    input  logic [ADDR_W-1:0]       dir_entry,
    input  logic [ADDR_W-1:0]       tbl_entry,
    output logic [ADDR_W-1:0]       dir_ent_addr,
    output logic [ADDR_W-1:0]       tbl_ent_addr,
    output logic [ADDR_W-1:0]       pa_small,
    output logic [ADDR_W-1:0]       pa_large
);
    localparam int unsigned ENT_SHIFT   = OFF_W - IDX_W;
    localparam int unsigned LARGE_OFF_W = OFF_W + IDX_W;

    // Entry addresses: frame base plus index scaled by entry size.
    always_comb begin
        dir_ent_addr = {base_frame, vaddr[ADDR_W-1 -: IDX_W], {ENT_SHIFT{1'b0}}};
        tbl_ent_addr = {dir_entry[ADDR_W-1:OFF_W], vaddr[LARGE_OFF_W-1:OFF_W],
                        {ENT_SHIFT{1'b0}}};
    end

    // Physical addresses for a 4 KB page and for a 4 MB page.
    always_comb begin
        pa_small = {tbl_entry[ADDR_W-1:OFF_W], vaddr[OFF_W-1:0]};
        pa_large = {dir_entry[ADDR_W-1:LARGE_OFF_W], vaddr[LARGE_OFF_W-1:0]};
    end
endmodule

// File: rtl/pt_entry_eval.sv
// Entry evaluator: checks presence and, for the final entry of a mapping,
// permissions combined with those granted by the level above. Also produces
// the entry with its use flags updated.
// Assumes the caller passes 1s for up_w/up_u when there is no upper level.
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int unsigned ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             up_w,
    input  logic             up_u,
    input  logic             leaf,
    input  logic             acc_write,
    input  logic             acc_user,
    output fault_e           cause,
    output logic [ENT_W-1:0] upd_entry,
    output logic             upd_changed
);
    // Fault decision: presence first, then privilege, then write permission.
    always_comb begin
        cause = FLT_NONE;
        if (!entry[BIT_PRESENT]) begin
            cause = FLT_NOT_PRESENT;
        end else if (leaf) begin
            if (acc_user && !(entry[BIT_USER] && up_u)) begin
                cause = FLT_PRIVILEGE;
            end else if (acc_write && !(entry[BIT_WRITABLE] && up_w)) begin
                cause = FLT_WRITE_PROT;
            end
        end
    end

    // Use-flag update: accessed always, dirty on a write to the final entry.
    always_comb begin
        upd_entry = entry;
        upd_entry[BIT_ACCESSED] = 1'b1;
        if (leaf && acc_write) begin
            upd_entry[BIT_DIRTY] = 1'b1;
        end
        upd_changed = (upd_entry != entry);
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker.
// Accepts one request while idle, reads the directory entry and, for a 4 KB
// mapping, the table entry, then writes back changed entries and answers with
// a done or fault pulse. Assumes the memory raises mem_ack for one cycle
// while mem_req is high, with read data valid in that cycle.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-OFF_W-1:0] dir_base_frame,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_cause,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic [ADDR_W-1:0] pa_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] FLAG_MASK =
        (ADDR_W'(1) << BIT_ACCESSED) | (ADDR_W'(1) << BIT_DIRTY);

    walk_state_e       state;
    logic [FRAME_W-1:0] base_q;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              usr_q;
    logic [ADDR_W-1:0] pde_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] pde_new_q;
    logic [ADDR_W-1:0] pte_new_q;
    logic              wb_tbl_q;
    fault_e            cause_q;
    logic [ADDR_W-1:0] pa_q;

    logic [ADDR_W-1:0] pde_src;
    logic [ADDR_W-1:0] dir_ent_addr;
    logic [ADDR_W-1:0] tbl_ent_addr;
    logic [ADDR_W-1:0] pa_small;
    logic [ADDR_W-1:0] pa_large;
    fault_e            d_cause;
    logic [ADDR_W-1:0] d_upd;
    logic              d_changed;
    fault_e            t_cause;
    logic [ADDR_W-1:0] t_upd;
    logic              t_changed;

    // Directory entry in use: live read data while it arrives, else the latched copy.
    always_comb begin
        pde_src = (state == ST_RD_DIR) ? mem_rdata : pde_q;
    end

    pt_addr_form #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .base_frame   (base_q),
        .vaddr        (va_q),
        .dir_entry    (pde_src),
        .tbl_entry    (mem_rdata),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .pa_small     (pa_small),
        .pa_large     (pa_large)
    );

    pt_entry_eval #(.ENT_W(ADDR_W)) u_dir_eval (
        .entry       (pde_src),
        .up_w        (1'b1),
        .up_u        (1'b1),
        .leaf        (pde_src[BIT_LARGE]),
        .acc_write   (wr_q),
        .acc_user    (usr_q),
        .cause       (d_cause),
        .upd_entry   (d_upd),
        .upd_changed (d_changed)
    );

    pt_entry_eval #(.ENT_W(ADDR_W)) u_tbl_eval (
        .entry       (mem_rdata),
        .up_w        (pde_q[BIT_WRITABLE]),
        .up_u        (pde_q[BIT_USER]),
        .leaf        (1'b1),
        .acc_write   (wr_q),
        .acc_user    (usr_q),
        .cause       (t_cause),
        .upd_entry   (t_upd),
        .upd_changed (t_changed)
    );

    // Walk sequencer: steps through reads, write-backs and the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            va_q      <= '0;
            wr_q      <= 1'b0;
            usr_q     <= 1'b0;
            pde_q     <= '0;
            pte_q     <= '0;
            pde_new_q <= '0;
            pte_new_q <= '0;
            wb_tbl_q  <= 1'b0;
            cause_q   <= FLT_NONE;
            pa_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        base_q  <= dir_base_frame;
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        cause_q <= FLT_NONE;
                        state   <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR: begin
                    if (mem_ack) begin
                        pde_q <= mem_rdata;
                        if (d_cause != FLT_NONE) begin
                            cause_q <= d_cause;
                            state   <= ST_RESP;
                        end else if (mem_rdata[BIT_LARGE]) begin
                            pa_q      <= pa_large;
                            pde_new_q <= d_upd;
                            wb_tbl_q  <= 1'b0;
                            state     <= d_changed ? ST_WB_DIR : ST_RESP;
                        end else begin
                            state <= ST_RD_TBL;
                        end
                    end
                end
                ST_RD_TBL: begin
                    if (mem_ack) begin
                        pte_q <= mem_rdata;
                        if (t_cause != FLT_NONE) begin
                            cause_q <= t_cause;
                            state   <= ST_RESP;
                        end else begin
                            pa_q      <= pa_small;
                            pde_new_q <= d_upd;
                            pte_new_q <= t_upd;
                            wb_tbl_q  <= t_changed;
                            if (d_changed) begin
                                state <= ST_WB_DIR;
                            end else if (t_changed) begin
                                state <= ST_WB_TBL;
                            end else begin
                                state <= ST_RESP;
                            end
                        end
                    end
                end
                ST_WB_DIR: begin
                    if (mem_ack) begin
                        state <= wb_tbl_q ? ST_WB_TBL : ST_RESP;
                    end
                end
                ST_WB_TBL: begin
                    if (mem_ack) begin
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Memory port: request fields selected by the current phase.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_ent_addr;
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_ent_addr;
            end
            ST_WB_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_ent_addr;
                mem_wdata = pde_new_q;
            end
            ST_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_ent_addr;
                mem_wdata = pte_new_q;
            end
            default: begin
            end
        endcase
    end

    // Response outputs.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_RESP) && (cause_q == FLT_NONE);
        fault       = (state == ST_RESP) && (cause_q != FLT_NONE);
        fault_cause = fault ? cause_q : FLT_NONE;
        fault_vaddr = va_q;
        pa_out      = pa_q;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || fault));

    // R3
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault |-> fault_cause != 2'd0) and (done |-> fault_cause == 2'd0));

    // R8
    wb_flags_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && state == ST_WB_DIR) |->
            ((mem_wdata & ~FLAG_MASK) == (pde_q & ~FLAG_MASK)));

    // R9
    wb_changed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            (mem_wdata != ((state == ST_WB_DIR) ? pde_q : pte_q)));
endmodule

// File: tb/tb_pt_walker.sv
// Sweep bench: every flag combination at both levels, every access kind,
// every preset use-flag state, with a memory model of varying latency.
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] dir_base_frame = 20'h00100;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        busy, done, fault;
    logic [1:0]  fault_cause;
    logic [31:0] fault_vaddr, pa_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] mem_q [logic [31:0]];
    int lat = 0;
    int wait_cnt = 0;
    int rd_cnt, wr_cnt, pulse_cnt;
    logic [31:0] rd_addr0, rd_addr1, wr_addr0;
    bit pend = 0;
    logic [31:0] pend_addr;

    always #4 clk = ~clk;

    pt_walker dut (
        .clk (clk), .rst_n (rst_n), .dir_base_frame (dir_base_frame),
        .req_valid (req_valid), .req_vaddr (req_vaddr), .req_write (req_write),
        .req_user (req_user), .busy (busy), .done (done), .fault (fault),
        .fault_cause (fault_cause), .fault_vaddr (fault_vaddr), .pa_out (pa_out),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model and port monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (done || fault) pulse_cnt++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            // R10: request fields must hold while waiting
            if (pend) chk(mem_addr == pend_addr, "R10 addr held", mem_addr, pend_addr);
            if (wait_cnt < lat) begin
                wait_cnt++;
                pend = 1;
                pend_addr = mem_addr;
            end else begin
                wait_cnt = 0;
                pend = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    if (wr_cnt == 0) wr_addr0 = mem_addr;
                    wr_cnt++;
                    mem_q[mem_addr] = mem_wdata;
                end else begin
                    if (rd_cnt == 0) rd_addr0 = mem_addr;
                    if (rd_cnt == 1) rd_addr1 = mem_addr;
                    rd_cnt++;
                    mem_rdata = mem_q.exists(mem_addr) ? mem_q[mem_addr] : 32'h0;
                end
            end
        end
    end

    task automatic run_walk(input int n);
        bit pP, pW, pU, pPS, tP, tW, tU, wr, usr, aD, aT, dT;
        logic [31:0] va, pde, pte, dir_a, tbl_a, exp_pa, exp_pde, exp_pte;
        logic [31:0] fin_pde, fin_pte;
        logic [1:0] exp_cause;
        int exp_rd, exp_wr;
        bit got, ok;
        logic [31:0] cap_pa, cap_fva;
        logic [1:0] cap_cause;
        bit cap_done;
        pP = n[0]; pW = n[1]; pU = n[2]; pPS = n[3];
        tP = n[4]; tW = n[5]; tU = n[6];
        wr = n[7]; usr = n[8];
        aD = n[9]; aT = n[10]; dT = n[11];
        va = {10'(n * 7 + 1), 10'(n * 3 + 2), 12'(n * 13)};
        if (pPS)
            pde = {10'(n * 37 + 3), 10'(n * 5), 4'h0, 1'b1, dT, aD, 2'b00, pU, pW, pP};
        else
            pde = {20'h00200 + 20'(n % 256), 4'h0, 1'b0, 1'b0, aD, 2'b00, pU, pW, pP};
        pte = {20'(n * 97 + 11), 4'h0, 1'b0, dT, aT, 2'b00, tU, tW, tP};
        dir_a = {dir_base_frame, va[31:22], 2'b00};
        tbl_a = {pde[31:12], va[21:12], 2'b00};
        mem_q.delete();
        mem_q[dir_a] = pde;
        mem_q[tbl_a] = pte;
        lat = n % 3;

        // Expected result, from the requirements.
        exp_cause = 2'd0;
        if (!pP) exp_cause = 2'd1;
        else if (pPS) begin
            if (usr && !pU) exp_cause = 2'd3;
            else if (wr && !pW) exp_cause = 2'd2;
        end else if (!tP) exp_cause = 2'd1;
        else if (usr && !(pU && tU)) exp_cause = 2'd3;
        else if (wr && !(pW && tW)) exp_cause = 2'd2;
        exp_rd = (!pP || pPS) ? 1 : 2;
        ok = (exp_cause == 2'd0);
        exp_pde = pde;
        exp_pte = pte;
        if (ok) begin
            exp_pde = pde | 32'h20 | ((pPS && wr) ? 32'h40 : 32'h0);
            if (!pPS) exp_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        end
        exp_wr = int'(exp_pde != pde) + int'(exp_pte != pte);
        exp_pa = pPS ? {pde[31:22], va[21:0]} : {pte[31:12], va[11:0]};

        rd_cnt = 0; wr_cnt = 0; pulse_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0;
        cap_done = 0; cap_cause = '0; cap_pa = '0; cap_fva = '0;
        for (int c = 0; c < 100 && !got; c++) begin
            if (done || fault) begin
                got = 1;
                cap_done = done;
                cap_cause = fault_cause;
                cap_pa = pa_out;
                cap_fva = fault_vaddr;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        chk(got, "R11 response seen", 32'(got), 32'd1);
        chk(pulse_cnt == 1 && !busy, "R11 single pulse then idle", 32'(pulse_cnt), 32'd1);
        // R3 R6 R7: outcome and cause
        chk(cap_done == ok && cap_cause == exp_cause, "R3 R6 R7 cause",
            {30'd0, cap_cause}, {30'd0, exp_cause});
        if (ok) chk(cap_pa == exp_pa, pPS ? "R4 large pa" : "R5 small pa", cap_pa, exp_pa);
        else chk(cap_fva == va, "R3 fault vaddr", cap_fva, va);
        // R1 R2 R4: read addresses and count
        chk(rd_cnt == exp_rd, "R4 read count", 32'(rd_cnt), 32'(exp_rd));
        chk(rd_addr0 == dir_a, "R1 directory address", rd_addr0, dir_a);
        if (exp_rd == 2) chk(rd_addr1 == tbl_a, "R2 table address", rd_addr1, tbl_a);
        fin_pde = mem_q[dir_a];
        fin_pte = mem_q[tbl_a];
        chk(fin_pde == exp_pde, "R8 directory entry flags", fin_pde, exp_pde);
        chk(fin_pte == exp_pte, "R8 table entry flags", fin_pte, exp_pte);
        chk(wr_cnt == exp_wr, "R9 write-back count", 32'(wr_cnt), 32'(exp_wr));
        if (exp_pde != pde) chk(wr_addr0 == dir_a, "R9 directory written first", wr_addr0, dir_a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy && !done && !fault && !mem_req, "R12 reset outputs",
            {28'd0, busy, done, fault, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R12 idle after reset", {30'd0, busy, mem_req}, 32'd0);
        for (int n = 0; n < 4096; n++) run_walk(n);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule